// File: doc/BRIEF.md
# Shared-Window Slot Configuration Commit

This block is the register front end of an eight-slot measurement monitor. Software never writes a slot directly. It fills one shared staging window of byte registers, names the target slot inside that window, raises a handshake flag and a conversion request, and then polls the handshake flag. The block copies the staged parameters into the private storage of the named slot a fixed number of cycles after the request and clears the flag. Only then may the next request be queued. Each slot's configuration is presented on dedicated output pins for the measurement engine, and each slot's latest 16-bit result, supplied by that engine on input pins, is readable as two bytes at fixed addresses.

The bus is a plain byte-wide register port with address, write data, write strobe, read strobe and registered read data. There is no back-pressure on it: every access completes in the cycle it is presented. Result and configuration pins carry levels and have no valid/ready handshake, since each slot value is static between commits. Software must keep the staging window unchanged until the handshake flag reads clear.

Top module: `slotcfg_commit`

## Requirements
- R1: After reset every staging byte, the handshake flag, the request bit, all slot outputs and the read data are zero.
- R2: Staging bytes at 0x40–0x46 and 0x49–0x4D read back the last byte written; read data appears on the cycle after the read strobe and holds while no read strobe is given.
- R3: A commit starts once both the handshake flag (bit 0 of 0x0D) and the request bit (bit 7 of 0x47) are set, in either order; writes to 0x0D only set the flag, a written 0 leaves it unchanged.
- R4: On commit, the slot named by bits 7:5 of 0x41 takes the staged values and no other slot changes. Slot parameter word layout: [7:0] source ID (0x40), [15:8] input select (0x44), [17:16] interval code (0x41 bits 3:2), [19:18] calibration select (0x42 bits 5:4), [21:20] decimation code (0x42 bits 3:2), [22] fast-average enable (0x43 bit 7), [25:23] average count code (0x43 bits 2:0), [29:26] settle delay code (0x45 bits 3:0).
- R5: Slot outputs update on the 4th clock edge after the edge that completes the request; on that same edge the handshake flag and the request bit both clear.
- R6: While bit 7 of the enable byte 0x46 is clear, a write setting the request bit is dropped: 0x47 reads 0, the handshake flag stays set and no slot changes.
- R7: A commit whose interrupt-enable byte 0x4D is zero switches the slot off: measurement enable and both threshold interrupt enables go low.
- R8: Thresholds are little-endian: low threshold = {0x4A, 0x49}, high threshold = {0x4C, 0x4B}; in 0x4D bit 7 is measurement enable, bit 1 the high-threshold interrupt enable, bit 0 the low-threshold interrupt enable.
- R9: The result of slot n reads at 0xA0+2n (bits 7:0) and 0xA1+2n (bits 15:8).
- R10: Reads of any other address, including 0x48, return zero; 0x0D reads the flag in bit 0 and 0x47 reads the request in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, registered |
| result_i | input | NSLOT*16 | Latest result per slot, slot n at bits 16n+15:16n |
| slot_param_o | output | NSLOT*30 | Per-slot parameter word, layout in R4 |
| slot_low_thr_o | output | NSLOT*16 | Per-slot low threshold |
| slot_high_thr_o | output | NSLOT*16 | Per-slot high threshold |
| slot_meas_en_o | output | NSLOT | Per-slot recurring measurement enable |
| slot_hi_irq_en_o | output | NSLOT | Per-slot high-threshold interrupt enable |
| slot_lo_irq_en_o | output | NSLOT | Per-slot low-threshold interrupt enable |

## Verification
Commits are issued to every slot with distinct field patterns, so a wrong slot decode or a swapped byte lane shows as a mismatch on a slot that should have stayed still. The request is raised both after and before the handshake flag, which separates a block that waits for both conditions from one that reacts to either alone, and the commit edge is probed one cycle early and on time to pin the latency. A request with the enable bit clear and a later retry with it set tell a dropped request apart from a deferred one, and a commit with a zero interrupt-enable byte shows that a slot can be switched off. Reads sweep the result addresses, the gap byte and unmapped addresses.

// File: rtl/slotcfg_pkg.sv
package slotcfg_pkg;
  localparam int WORD_W     = 16;
  localparam int WIN_BYTES  = 14;
  localparam int SEL_W      = 3;

  localparam logic [7:0] A_HANDSHAKE   = 8'h0D;
  localparam logic [7:0] A_WIN_BASE    = 8'h40;
  localparam logic [7:0] A_REQUEST     = 8'h47;
  localparam logic [7:0] A_RESULT_BASE = 8'hA0;

  // byte positions inside the staging window
  localparam int IX_SRC    = 0;
  localparam int IX_CTL    = 1;
  localparam int IX_DIG    = 2;
  localparam int IX_AVG    = 3;
  localparam int IX_INSEL  = 4;
  localparam int IX_DELAY  = 5;
  localparam int IX_ENABLE = 6;
  localparam int IX_REQ    = 7;
  localparam int IX_GAP    = 8;
  localparam int IX_LTH_L  = 9;
  localparam int IX_LTH_H  = 10;
  localparam int IX_HTH_L  = 11;
  localparam int IX_HTH_H  = 12;
  localparam int IX_IRQ    = 13;

  typedef struct packed {
    logic [3:0] settle;
    logic [2:0] avg_cnt;
    logic       fast_avg;
    logic [1:0] decim;
    logic [1:0] cal_sel;
    logic [1:0] interval;
    logic [7:0] in_sel;
    logic [7:0] src_id;
  } slot_param_t;

  localparam int PARAM_W = $bits(slot_param_t);
endpackage

// File: rtl/slotcfg_stage.sv
module slotcfg_stage
  import slotcfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [7:0]             addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   done_i,
  output slot_param_t            param_o,
  output logic [WORD_W-1:0]      low_thr_o,
  output logic [WORD_W-1:0]      high_thr_o,
  output logic                   meas_en_o,
  output logic                   hi_irq_o,
  output logic                   lo_irq_o,
  output logic [SEL_W-1:0]       sel_o,
  output logic                   hs_o,
  output logic                   req_o,
  output logic                   en_o,
  output logic [WIN_BYTES*8-1:0] win_flat_o
);
  logic [WIN_BYTES*8-1:0] win_flat;
  logic [7:0]             win_off;
  logic                   wr_win;
  logic                   hs_q;
  logic                   req_q;

  assign win_off = addr_i - A_WIN_BASE;
  assign wr_win  = wr_en_i && (addr_i >= A_WIN_BASE) &&
                   (addr_i < A_WIN_BASE + 8'(WIN_BYTES));

  generate
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
      if (i == IX_REQ) begin : g_req
        assign win_flat[i*8 +: 8] = {req_q, 7'b0};
      end else if (i == IX_GAP) begin : g_gap
        assign win_flat[i*8 +: 8] = 8'h00;
      end else begin : g_reg
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            byte_q <= 8'h00;
          end else if (wr_win && (win_off == 8'(i))) begin
            byte_q <= wdata_i;
          end
        end
        assign win_flat[i*8 +: 8] = byte_q;
      end
    end
  endgenerate

  assign en_o = win_flat[IX_ENABLE*8 + 7];

  // handshake flag: set by software, cleared by a finished commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
    end else begin
      if (done_i) hs_q <= 1'b0;
      if (wr_en_i && (addr_i == A_HANDSHAKE) && wdata_i[0]) hs_q <= 1'b1;
    end
  end

  // request bit: latched only while the enable bit is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      if (done_i) req_q <= 1'b0;
      if (wr_en_i && (addr_i == A_REQUEST) && wdata_i[7] && en_o) req_q <= 1'b1;
    end
  end

  always_comb begin
    param_o.src_id   = win_flat[IX_SRC*8 +: 8];
    param_o.in_sel   = win_flat[IX_INSEL*8 +: 8];
    param_o.interval = win_flat[IX_CTL*8 + 2 +: 2];
    param_o.cal_sel  = win_flat[IX_DIG*8 + 4 +: 2];
    param_o.decim    = win_flat[IX_DIG*8 + 2 +: 2];
    param_o.fast_avg = win_flat[IX_AVG*8 + 7];
    param_o.avg_cnt  = win_flat[IX_AVG*8 +: 3];
    param_o.settle   = win_flat[IX_DELAY*8 +: 4];
  end

  assign sel_o      = win_flat[IX_CTL*8 + 5 +: SEL_W];
  assign low_thr_o  = {win_flat[IX_LTH_H*8 +: 8], win_flat[IX_LTH_L*8 +: 8]};
  assign high_thr_o = {win_flat[IX_HTH_H*8 +: 8], win_flat[IX_HTH_L*8 +: 8]};
  assign meas_en_o  = win_flat[IX_IRQ*8 + 7];
  assign hi_irq_o   = win_flat[IX_IRQ*8 + 1];
  assign lo_irq_o   = win_flat[IX_IRQ*8 + 0];
  assign hs_o       = hs_q;
  assign req_o      = req_q;
  assign win_flat_o = win_flat;
endmodule

// File: rtl/slotcfg_ctrl.sv
module slotcfg_ctrl #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_i,
  input  logic req_i,
  output logic done_o
);
  localparam int CW = (LAT > 2) ? $clog2(LAT - 1) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (hs_i && req_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LAT - 2);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/slotcfg_bank.sv
module slotcfg_bank
  import slotcfg_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      done_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  slot_param_t               param_i,
  input  logic [WORD_W-1:0]         low_thr_i,
  input  logic [WORD_W-1:0]         high_thr_i,
  input  logic                      meas_en_i,
  input  logic                      hi_irq_i,
  input  logic                      lo_irq_i,
  output logic [NSLOT*PARAM_W-1:0]  param_o,
  output logic [NSLOT*WORD_W-1:0]   low_thr_o,
  output logic [NSLOT*WORD_W-1:0]   high_thr_o,
  output logic [NSLOT-1:0]          meas_en_o,
  output logic [NSLOT-1:0]          hi_irq_o,
  output logic [NSLOT-1:0]          lo_irq_o
);
  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic              load;
      slot_param_t       par_q;
      logic [WORD_W-1:0] lo_q;
      logic [WORD_W-1:0] hi_q;
      logic              me_q;
      logic              hie_q;
      logic              loe_q;

      assign load = done_i && (sel_i == SEL_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          par_q <= '0;
          lo_q  <= '0;
          hi_q  <= '0;
          me_q  <= 1'b0;
          hie_q <= 1'b0;
          loe_q <= 1'b0;
        end else if (load) begin
          par_q <= param_i;
          lo_q  <= low_thr_i;
          hi_q  <= high_thr_i;
          me_q  <= meas_en_i;
          hie_q <= hi_irq_i;
          loe_q <= lo_irq_i;
        end
      end

      assign param_o[s*PARAM_W +: PARAM_W] = par_q;
      assign low_thr_o[s*WORD_W +: WORD_W]  = lo_q;
      assign high_thr_o[s*WORD_W +: WORD_W] = hi_q;
      assign meas_en_o[s] = me_q;
      assign hi_irq_o[s]  = hie_q;
      assign lo_irq_o[s]  = loe_q;
    end
  endgenerate
endmodule

// File: rtl/slotcfg_rdmux.sv
module slotcfg_rdmux
  import slotcfg_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en_i,
  input  logic [7:0]              addr_i,
  input  logic                    hs_i,
  input  logic [WIN_BYTES*8-1:0]  win_flat_i,
  input  logic [NSLOT*WORD_W-1:0] result_i,
  output logic [7:0]              rdata_o
);
  localparam int RES_BYTES = NSLOT * (WORD_W / 8);

  logic [7:0] off_w;
  logic [7:0] off_r;
  logic [7:0] nxt;

  always_comb begin
    off_w = addr_i - A_WIN_BASE;
    off_r = addr_i - A_RESULT_BASE;
    nxt   = 8'h00;
    if (addr_i == A_HANDSHAKE) begin
      nxt = {7'b0, hs_i};
    end else if ((addr_i >= A_WIN_BASE) && ({1'b0, off_w} < 9'(WIN_BYTES))) begin
      nxt = win_flat_i[int'(off_w)*8 +: 8];
    end else if ((addr_i >= A_RESULT_BASE) && ({1'b0, off_r} < 9'(RES_BYTES))) begin
      nxt = result_i[int'(off_r)*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= 8'h00;
    end else if (rd_en_i) begin
      rdata_o <= nxt;
    end
  end
endmodule

// File: rtl/slotcfg_commit.sv
module slotcfg_commit
  import slotcfg_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int COMMIT_LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               bus_addr_i,
  input  logic [7:0]               bus_wdata_i,
  input  logic                     bus_wr_i,
  input  logic                     bus_rd_i,
  output logic [7:0]               bus_rdata_o,
  input  logic [NSLOT*WORD_W-1:0]  result_i,
  output logic [NSLOT*PARAM_W-1:0] slot_param_o,
  output logic [NSLOT*WORD_W-1:0]  slot_low_thr_o,
  output logic [NSLOT*WORD_W-1:0]  slot_high_thr_o,
  output logic [NSLOT-1:0]         slot_meas_en_o,
  output logic [NSLOT-1:0]         slot_hi_irq_en_o,
  output logic [NSLOT-1:0]         slot_lo_irq_en_o
);
  slot_param_t            stg_param;
  logic [WORD_W-1:0]      stg_low;
  logic [WORD_W-1:0]      stg_high;
  logic                   stg_meas;
  logic                   stg_hie;
  logic                   stg_loe;
  logic [SEL_W-1:0]       stg_sel;
  logic                   hs_q;
  logic                   req_q;
  logic                   en_bit;
  logic                   done;
  logic [WIN_BYTES*8-1:0] win_flat;

  slotcfg_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .done_i     (done),
    .param_o    (stg_param),
    .low_thr_o  (stg_low),
    .high_thr_o (stg_high),
    .meas_en_o  (stg_meas),
    .hi_irq_o   (stg_hie),
    .lo_irq_o   (stg_loe),
    .sel_o      (stg_sel),
    .hs_o       (hs_q),
    .req_o      (req_q),
    .en_o       (en_bit),
    .win_flat_o (win_flat)
  );

  slotcfg_ctrl #(.LAT(COMMIT_LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_i   (hs_q),
    .req_i  (req_q),
    .done_o (done)
  );

  slotcfg_bank #(.NSLOT(NSLOT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .sel_i      (stg_sel),
    .param_i    (stg_param),
    .low_thr_i  (stg_low),
    .high_thr_i (stg_high),
    .meas_en_i  (stg_meas),
    .hi_irq_i   (stg_hie),
    .lo_irq_i   (stg_loe),
    .param_o    (slot_param_o),
    .low_thr_o  (slot_low_thr_o),
    .high_thr_o (slot_high_thr_o),
    .meas_en_o  (slot_meas_en_o),
    .hi_irq_o   (slot_hi_irq_en_o),
    .lo_irq_o   (slot_lo_irq_en_o)
  );

  slotcfg_rdmux #(.NSLOT(NSLOT)) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (bus_rd_i),
    .addr_i     (bus_addr_i),
    .hs_i       (hs_q),
    .win_flat_i (win_flat),
    .result_i   (result_i),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/slotcfg_commit_chk.sv
module slotcfg_commit_chk #(
  parameter int COMMIT_LAT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] addr,
  input logic       wbit0,
  input logic [7:0] rdata,
  input logic [7:0] res0_lo,
  input logic       hs,
  input logic       req,
  input logic       en
);
  logic [7:0] req_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_run <= 8'd0;
    end else if (!req) begin
      req_run <= 8'd0;
    end else if (req_run != 8'hFF) begin
      req_run <= req_run + 8'd1;
    end
  end

  AST_HS_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> $past(wr_en && (addr == 8'h0D) && wbit0)); // R3

  AST_REQ_HELD_FULL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> (req_run >= 8'(COMMIT_LAT))); // R5

  AST_HS_CLEARS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs) |-> !req); // R5

  AST_REQ_DROPPED_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req) |=> !req); // R6

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2

  AST_RESULT0_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 8'hA0)) |=> (rdata == $past(res0_lo))); // R9

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ((addr == 8'h48) || (addr == 8'h00))) |=> (rdata == 8'h00)); // R10
endmodule

bind slotcfg_commit slotcfg_commit_chk #(.COMMIT_LAT(COMMIT_LAT)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (bus_wr_i),
  .rd_en   (bus_rd_i),
  .addr    (bus_addr_i),
  .wbit0   (bus_wdata_i[0]),
  .rdata   (bus_rdata_o),
  .res0_lo (result_i[7:0]),
  .hs      (hs_q),
  .req     (req_q),
  .en      (en_bit)
);

// File: tb/slotcfg_commit_tb_top.sv
`timescale 1ns/1ps
module slotcfg_commit_tb_top;
  import slotcfg_pkg::*;

  localparam int NSLOT = 8;
  localparam int LAT   = 4;
  localparam int PW    = PARAM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]              addr = 8'h00;
  logic [7:0]              wdata = 8'h00;
  logic                    wr = 1'b0;
  logic                    rd = 1'b0;
  logic [7:0]              rdata;
  logic [NSLOT*WORD_W-1:0] res = '0;
  logic [NSLOT*PW-1:0]     s_par;
  logic [NSLOT*WORD_W-1:0] s_lo;
  logic [NSLOT*WORD_W-1:0] s_hi;
  logic [NSLOT-1:0]        s_me;
  logic [NSLOT-1:0]        s_hie;
  logic [NSLOT-1:0]        s_loe;

  slotcfg_commit #(.NSLOT(NSLOT), .COMMIT_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata), .result_i(res),
    .slot_param_o(s_par), .slot_low_thr_o(s_lo), .slot_high_thr_o(s_hi),
    .slot_meas_en_o(s_me), .slot_hi_irq_en_o(s_hie), .slot_lo_irq_en_o(s_loe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]        m_win [WIN_BYTES];
  logic              m_hs, m_req;
  int                m_wait;
  logic [PW-1:0]     m_par [NSLOT];
  logic [WORD_W-1:0] m_lo [NSLOT];
  logic [WORD_W-1:0] m_hi [NSLOT];
  logic              m_me [NSLOT];
  logic              m_hie [NSLOT];
  logic              m_loe [NSLOT];
  logic [7:0]        m_rd;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a == 8'h0D) return {7'b0, m_hs};
    if (a == 8'h47) return {m_req, 7'b0};
    if (a == 8'h48) return 8'h00;
    if (a >= 8'h40 && a <= 8'h4D) return m_win[a - 8'h40];
    if (a >= 8'hA0 && a < 8'hA0 + 8'(2 * NSLOT)) return res[(a - 8'hA0) * 8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_BYTES; i++) m_win[i] = 8'h00;
      for (int s = 0; s < NSLOT; s++) begin
        m_par[s] = '0; m_lo[s] = '0; m_hi[s] = '0;
        m_me[s] = 1'b0; m_hie[s] = 1'b0; m_loe[s] = 1'b0;
      end
      m_hs = 1'b0; m_req = 1'b0; m_wait = -1; m_rd = 8'h00;
    end else begin
      logic en_old;
      int sl;
      en_old = m_win[6][7];
      if (rd) m_rd = model_read(addr);
      if (m_wait > 0) begin
        m_wait--;
      end else if (m_wait == 0) begin
        sl = int'(m_win[1][7:5]);
        m_par[sl] = {m_win[5][3:0], m_win[3][2:0], m_win[3][7], m_win[2][3:2],
                     m_win[2][5:4], m_win[1][3:2], m_win[4], m_win[0]};
        m_lo[sl]  = {m_win[10], m_win[9]};
        m_hi[sl]  = {m_win[12], m_win[11]};
        m_me[sl]  = m_win[13][7];
        m_hie[sl] = m_win[13][1];
        m_loe[sl] = m_win[13][0];
        m_hs = 1'b0; m_req = 1'b0; m_wait = -1;
      end else if (m_hs && m_req) begin
        m_wait = LAT - 2;
      end
      if (wr) begin
        if (addr == 8'h0D) begin
          if (wdata[0]) m_hs = 1'b1;
        end else if (addr == 8'h47) begin
          if (wdata[7] && en_old) m_req = 1'b1;
        end else if (addr >= 8'h40 && addr <= 8'h4D && addr != 8'h48) begin
          m_win[addr - 8'h40] = wdata;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 read data vs model", {56'h0, rdata}, {56'h0, m_rd});
      for (int s = 0; s < NSLOT; s++) begin
        chk("R4 slot param/enables vs model",
            {31'h0, s_me[s], s_hie[s], s_loe[s], s_par[s*PW +: PW]},
            {31'h0, m_me[s], m_hie[s], m_loe[s], m_par[s]});
        chk("R8 slot thresholds vs model",
            {32'h0, s_hi[s*WORD_W +: WORD_W], s_lo[s*WORD_W +: WORD_W]},
            {32'h0, m_hi[s], m_lo[s]});
      end
    end
  end

  // ---------------- bus tasks (entered at a falling edge) ----------------
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic commit();
    wr_reg(8'h0D, 8'h01);
    wr_reg(8'h47, 8'h80);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] d;
    for (int s = 0; s < NSLOT; s++) res[s*WORD_W +: WORD_W] = 16'(16'hC3A1 + s * 16'h1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 meas enables", {56'h0, s_me}, 64'h0);
    chk("R1 params", {34'h0, s_par[PW-1:0]}, 64'h0);
    rd_reg(8'h0D, d); chk("R1 handshake flag", {56'h0, d}, 64'h0);
    rd_reg(8'h41, d); chk("R1 staging byte", {56'h0, d}, 64'h0);

    // R2: staging readback
    for (int a = 8'h40; a <= 8'h4D; a++)
      if (a != 8'h47 && a != 8'h48) wr_reg(8'(a), 8'(a) ^ 8'h5C);
    for (int a = 8'h40; a <= 8'h4D; a++)
      if (a != 8'h47 && a != 8'h48) begin
        rd_reg(8'(a), d);
        chk("R2 staging readback", {56'h0, d}, {56'h0, 8'(a) ^ 8'h5C});
      end
    rd_reg(8'h48, d); chk("R10 gap byte reads zero", {56'h0, d}, 64'h0);

    // R4/R5/R8: configure slot 3 and time the commit
    wr_reg(8'h46, 8'h80);
    wr_reg(8'h40, 8'h12); wr_reg(8'h41, 8'h68); wr_reg(8'h42, 8'h34);
    wr_reg(8'h43, 8'h85); wr_reg(8'h44, 8'h5A); wr_reg(8'h45, 8'h0B);
    wr_reg(8'h49, 8'h34); wr_reg(8'h4A, 8'h12); wr_reg(8'h4B, 8'hEF);
    wr_reg(8'h4C, 8'hBE); wr_reg(8'h4D, 8'h83);
    commit();
    for (int k = 1; k <= 4; k++) begin
      idle(1);
      chk("R5 commit lands on 4th edge", {63'h0, s_me[3]}, {63'h0, (k == 4)});
    end
    chk("R4 slot 3 parameter word", {34'h0, s_par[3*PW +: PW]},
        {34'h0, 4'hB, 3'd5, 1'b1, 2'd1, 2'd3, 2'd2, 8'h5A, 8'h12});
    chk("R8 slot 3 low threshold", {48'h0, s_lo[3*WORD_W +: WORD_W]}, 64'h1234);
    chk("R8 slot 3 high threshold", {48'h0, s_hi[3*WORD_W +: WORD_W]}, 64'hBEEF);
    chk("R8 slot 3 irq enables", {61'h0, s_me[3], s_hie[3], s_loe[3]}, 64'h7);
    chk("R4 slot 2 untouched", {34'h0, s_par[2*PW +: PW]}, 64'h0);
    rd_reg(8'h0D, d); chk("R5 handshake cleared", {56'h0, d}, 64'h0);
    rd_reg(8'h47, d); chk("R5 request cleared", {56'h0, d}, 64'h0);

    // R3: writing 0 to the handshake does not set it
    wr_reg(8'h0D, 8'h00);
    rd_reg(8'h0D, d); chk("R3 zero write leaves flag", {56'h0, d}, 64'h0);

    // R7: zero interrupt-enable byte switches slot 3 off
    wr_reg(8'h4D, 8'h00);
    commit(); idle(5);
    chk("R7 slot 3 off", {61'h0, s_me[3], s_hie[3], s_loe[3]}, 64'h0);

    // R6: request dropped while disabled, then retried
    wr_reg(8'h46, 8'h00); wr_reg(8'h41, 8'hA0); wr_reg(8'h4D, 8'h83);
    commit(); idle(6);
    rd_reg(8'h47, d); chk("R6 request dropped", {56'h0, d}, 64'h0);
    rd_reg(8'h0D, d); chk("R6 handshake stays set", {56'h0, d}, 64'h1);
    chk("R6 slot 5 unchanged", {63'h0, s_me[5]}, 64'h0);
    wr_reg(8'h46, 8'h80); wr_reg(8'h47, 8'h80); idle(5);
    chk("R3 retry commits slot 5", {61'h0, s_me[5], s_hie[5], s_loe[5]}, 64'h7);

    // R3/R5: request before handshake
    wr_reg(8'h41, 8'hC4); wr_reg(8'h4D, 8'h80);
    wr_reg(8'h47, 8'h80); idle(3);
    chk("R3 request alone does not commit", {63'h0, s_me[6]}, 64'h0);
    wr_reg(8'h0D, 8'h01); idle(3);
    chk("R5 not yet committed", {63'h0, s_me[6]}, 64'h0);
    idle(1);
    chk("R5 committed after flag", {63'h0, s_me[6]}, 64'h1);

    // R4/R8: sweep every slot with its own pattern
    for (int s = 0; s < NSLOT; s++) begin
      wr_reg(8'h41, {3'(s), 1'b0, 2'(s % 4), 2'b00});
      wr_reg(8'h49, 8'(s * 17)); wr_reg(8'h4A, 8'(8'hA0 + s));
      wr_reg(8'h4B, 8'(8'h0F ^ s)); wr_reg(8'h4C, 8'(8'h70 + s));
      wr_reg(8'h4D, (s % 2 == 1) ? 8'h81 : 8'h82);
      commit(); idle(5);
      chk("R8 sweep low threshold", {48'h0, s_lo[s*WORD_W +: WORD_W]},
          {48'h0, 8'(8'hA0 + s), 8'(s * 17)});
      chk("R8 sweep high threshold", {48'h0, s_hi[s*WORD_W +: WORD_W]},
          {48'h0, 8'(8'h70 + s), 8'(8'h0F ^ s)});
      chk("R4 sweep interval field", {62'h0, s_par[s*PW + 16 +: 2]}, {62'h0, 2'(s % 4)});
    end

    // R9: results; R10: unmapped
    for (int s = 0; s < NSLOT; s++) begin
      rd_reg(8'(8'hA0 + 2 * s), d);
      chk("R9 result low byte", {56'h0, d}, {56'h0, res[s*WORD_W +: 8]});
      rd_reg(8'(8'hA1 + 2 * s), d);
      chk("R9 result high byte", {56'h0, d}, {56'h0, res[s*WORD_W + 8 +: 8]});
    end
    rd_reg(8'h00, d); chk("R10 address 0x00", {56'h0, d}, 64'h0);
    rd_reg(8'h50, d); chk("R10 address 0x50", {56'h0, d}, 64'h0);
    rd_reg(8'hB0, d); chk("R10 address 0xB0", {56'h0, d}, 64'h0);
    rd_reg(8'hFF, d); chk("R10 address 0xFF", {56'h0, d}, 64'h0);
    idle(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule